// File: doc/BRIEF.md
# Two-Phase Cascaded Delay Timer

This block measures two delays in succession on one system clock. Each delay comes from a stage built of a free-running binary prescaler and a ten-position one-hot sequencer. A select input picks which prescaler bit acts as the stage's tick. Each rising edge of that bit moves the sequencer one position forward. A second select names the sequencer position that ends the stage.

When the first stage reaches its chosen position, it freezes its own prescaler and keeps its result. That same event lets the second stage out of reset, and the second stage then counts from zero. When the second stage reaches its own chosen position, the load output rises and stays high until reset.

A user sets the start delay with the first pair of selects and the countdown length with the second pair. The two pairs do not interact. The phase output shows whether the timer is waiting in the first stage, counting in the second stage, or finished.

Top module: `dual_phase_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge forces `phase_o` to 2'b00 (waiting) and `load_o` to 0.
- R2: A tap select of k makes prescaler bit k the stage tick. After the stage is released, its first rising edge comes 2^k clock edges later, and each further one comes 2^(k+1) edges after the previous.
- R3: With start tap k and position N (1..9), `phase_o` changes from 2'b00 to 2'b01 at exactly (2N-1)*2^k clock edges after the first edge with `rst_n` high, and never goes back to 2'b00 before reset.
- R4: A position select of 0 behaves exactly like a position select of 1.
- R5: Position select values 10 to 15 behave exactly like 9.
- R6: The second stage stays cleared until the first stage finishes. With run tap j and position M, `phase_o` becomes 2'b10 and `load_o` becomes 1 exactly (2M-1)*2^j edges after the edge at which `phase_o` became 2'b01.
- R7: Once `phase_o` is 2'b10 and `load_o` is 1, both hold until reset, whatever the four select inputs do.
- R8: `phase_o` never shows 2'b11 and never moves from 2'b00 to 2'b10 in one edge.
- R9: The start selects affect only the first delay and the run selects affect only the second. Swapping the two settings swaps the two intervals.
- R10: A reset applied partway through a delay brings the block back to the R1 state. The next run is timed from the new release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_tap_sel | input | TAP_W (3) | Prescaler bit used as tick by the first stage |
| start_pos_sel | input | 4 | Finishing sequencer position of the first stage |
| run_tap_sel | input | TAP_W (3) | Prescaler bit used as tick by the second stage |
| run_pos_sel | input | 4 | Finishing sequencer position of the second stage |
| load_o | output | 1 | Latched high when the second stage finishes |
| phase_o | output | 2 | 00 waiting, 01 counting, 10 done |

## Verification
The shortest setting (tap 0, position 1 in both stages) leaves one clock edge per phase. An off-by-one in the edge detection, or a second stage that is released one cycle late, shows up there as a shifted phase change. Position selects of 0 and above 9 are exercised. A design that skipped the clamp would never finish, or would finish immediately, and the per-phase cycle checks catch either. After completion the selects are changed on purpose. A stage that did not freeze its prescaler, or read its selects without latching done, would drop or move the load output. A reset in the middle of a long delay checks that no leftover count shortens the next run.

// File: rtl/dpt_pkg.sv
// Shared definitions for the two-phase cascaded delay timer.
// Assumes ten sequencer positions and a 4-bit position select.
package dpt_pkg;

    localparam int SEQ_POSITIONS = 10;
    localparam int POS_W         = 4;
    localparam int STAGES        = 2;

    typedef enum logic [1:0] {
        PH_WAIT  = 2'b00,
        PH_COUNT = 2'b01,
        PH_DONE  = 2'b10
    } phase_e;

    // Map a raw position select onto the legal range 1..SEQ_POSITIONS-1
    function automatic logic [POS_W-1:0] clamp_pos(input logic [POS_W-1:0] raw);
        logic [POS_W-1:0] top_pos;
        top_pos = POS_W'(SEQ_POSITIONS - 1);
        if (raw == '0) begin
            return POS_W'(1);
        end
        if (raw > top_pos) begin
            return top_pos;
        end
        return raw;
    endfunction

endpackage

// File: rtl/dpt_prescaler.sv
// Free-running binary prescaler with a selectable tap.
// Emits a one-cycle tick on the clock edge at which the chosen bit
// rises. The clear input zeroes the count; the hold input freezes it.
// Assumes tap_sel values beyond CNT_W-1 are clamped to the top bit.
module dpt_prescaler #(
    parameter int CNT_W = 8,
    parameter int TAP_W = $clog2(CNT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             hold,
    input  logic [TAP_W-1:0] tap_sel,
    output logic             tick
);

    localparam logic [TAP_W-1:0] TAP_MAX = TAP_W'(CNT_W - 1);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_nxt;
    logic [TAP_W-1:0] tap_eff;

    // Limit the tap index to an existing counter bit
    always_comb begin
        tap_eff = (tap_sel > TAP_MAX) ? TAP_MAX : tap_sel;
    end

    // Next count and rising-edge detection of the chosen bit
    always_comb begin
        count_nxt = count_q + CNT_W'(1);
        tick      = !hold && !clear && count_nxt[tap_eff] && !count_q[tap_eff];
    end

    // Counter register: cleared by reset or clear, frozen by hold
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count_q <= '0;
        end else if (!hold) begin
            count_q <= count_nxt;
        end
    end

endmodule

// File: rtl/dpt_sequencer.sv
// Ten-position one-hot sequencer. Position 0 is active after reset or
// clear; each advance pulse rotates the active bit to the next
// position. Assumes advance is a one-cycle enable.
module dpt_sequencer #(
    parameter int POSITIONS = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 advance,
    output logic [POSITIONS-1:0] ring
);

    localparam logic [POSITIONS-1:0] HOME = POSITIONS'(1);

    logic [POSITIONS-1:0] ring_q;
    logic [POSITIONS-1:0] ring_rot;

    // Rotated copy built bit by bit
    for (genvar p = 0; p < POSITIONS; p++) begin : g_rot
        if (p == 0) begin : g_wrap
            assign ring_rot[p] = ring_q[POSITIONS-1];
        end else begin : g_shift
            assign ring_rot[p] = ring_q[p-1];
        end
    end

    // Ring register: home on reset or clear, rotate on advance
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ring_q <= HOME;
        end else if (advance) begin
            ring_q <= ring_rot;
        end
    end

    assign ring = ring_q;

endmodule

// File: rtl/dpt_stage.sv
// One timing stage: prescaler, sequencer and a sticky done flag.
// While enable is low the stage is held cleared. On the tick that
// moves the sequencer into the chosen position, done sets. Done then
// freezes the prescaler, so the sequencer stays put as well.
// Assumes pos_sel is clamped to 1..9 through the package helper.
module dpt_stage
    import dpt_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int TAP_W = $clog2(CNT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [TAP_W-1:0] tap_sel,
    input  logic [POS_W-1:0] pos_sel,
    output logic             done
);

    logic                     tick;
    logic                     done_q;
    logic [SEQ_POSITIONS-1:0] ring;
    logic [POS_W-1:0]         pos_eff;
    logic [POS_W-1:0]         pos_before;
    logic                     reach;

    // Prescaler frozen once the stage has finished
    dpt_prescaler #(
        .CNT_W (CNT_W),
        .TAP_W (TAP_W)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!enable),
        .hold    (done_q),
        .tap_sel (tap_sel),
        .tick    (tick)
    );

    // Sequencer stepped by the prescaler tick
    dpt_sequencer #(
        .POSITIONS (SEQ_POSITIONS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!enable),
        .advance (tick),
        .ring    (ring)
    );

    // Position just before the finishing one
    always_comb begin
        pos_eff    = clamp_pos(pos_sel);
        pos_before = pos_eff - POS_W'(1);
        reach      = tick && ring[pos_before];
    end

    // Sticky done flag set on the finishing tick
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            done_q <= 1'b0;
        end else if (reach) begin
            done_q <= 1'b1;
        end
    end

    assign done = done_q;

endmodule

// File: rtl/dual_phase_timer.sv
// Two-phase cascaded delay timer. Stage 0 times the start delay and is
// always enabled out of reset; stage 1 is held cleared until stage 0
// is done and then times the countdown. The load output follows the
// done flag of stage 1 and the phase output encodes progress.
// Assumes one clock domain and a synchronous active-low reset.
module dual_phase_timer
    import dpt_pkg::*;
#(
    parameter  int PRESC_W = 8,
    localparam int TAP_W   = $clog2(PRESC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAP_W-1:0] start_tap_sel,
    input  logic [3:0]       start_pos_sel,
    input  logic [TAP_W-1:0] run_tap_sel,
    input  logic [3:0]       run_pos_sel,
    output logic             load_o,
    output logic [1:0]       phase_o
);

    logic [STAGES-1:0] stage_done;
    logic [TAP_W-1:0]  tap_arr [STAGES];
    logic [POS_W-1:0]  pos_arr [STAGES];
    phase_e            phase;

    // Gather per-stage selects into arrays
    always_comb begin
        tap_arr[0] = start_tap_sel;
        tap_arr[1] = run_tap_sel;
        pos_arr[0] = start_pos_sel;
        pos_arr[1] = run_pos_sel;
    end

    // Chain of stages, each released by the done flag of the previous
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic stage_en;
        if (s == 0) begin : g_first
            assign stage_en = 1'b1;
        end else begin : g_next
            assign stage_en = stage_done[s-1];
        end
        dpt_stage #(
            .CNT_W (PRESC_W),
            .TAP_W (TAP_W)
        ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .enable  (stage_en),
            .tap_sel (tap_arr[s]),
            .pos_sel (pos_arr[s]),
            .done    (stage_done[s])
        );
    end

    // Phase decode from the stage done flags
    always_comb begin
        if (stage_done[STAGES-1]) begin
            phase = PH_DONE;
        end else if (stage_done[0]) begin
            phase = PH_COUNT;
        end else begin
            phase = PH_WAIT;
        end
    end

    assign phase_o = phase;
    assign load_o  = stage_done[STAGES-1];

endmodule

// File: rtl/dpt_timer_chk.sv
// Property checker for dual_phase_timer, attached through bind.
module dpt_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       load_o,
    input logic [1:0] phase_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (phase_o == 2'b00 && !load_o));

    // R8
    phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o != 2'b11);

    // R8
    no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o == 2'b00 |=> phase_o != 2'b10);

    // R3
    start_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o != 2'b00 |=> phase_o != 2'b00);

    // R7
    load_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> load_o);

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o == 2'b10 |=> phase_o == 2'b10);

endmodule

bind dual_phase_timer dpt_timer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_o  (load_o),
    .phase_o (phase_o)
);

// File: tb/dual_phase_timer_test.sv
`timescale 1ns/1ps
module dual_phase_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] start_tap_sel = '0;
    logic [3:0] start_pos_sel = 4'd1;
    logic [2:0] run_tap_sel = '0;
    logic [3:0] run_pos_sel = 4'd1;
    logic       load_o;
    logic [1:0] phase_o;

    int checks = 0;
    int fails  = 0;
    int unsigned cyc = 0;
    logic [1:0] prev_ph = 2'b00;

    typedef struct {
        logic [1:0]  ph;
        int unsigned at;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    dual_phase_timer uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_tap_sel (start_tap_sel),
        .start_pos_sel (start_pos_sel),
        .run_tap_sel   (run_tap_sel),
        .run_pos_sel   (run_pos_sel),
        .load_o        (load_o),
        .phase_o       (phase_o)
    );

    always #4 clk = ~clk;

    // Edges seen with reset released
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    function automatic int unsigned eff_pos(input logic [3:0] n);
        if (n == 0) return 1;
        if (n > 9)  return 9;
        return n;
    endfunction

    function automatic int unsigned span(input logic [2:0] k, input logic [3:0] n);
        return (2 * eff_pos(n) - 1) << k;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Monitor: every phase change pops and compares the next expected item
    always @(negedge clk) begin
        if (rst_n && phase_o != prev_ph) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected phase change to", int'(phase_o), int'(prev_ph));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(phase_o == e.ph, e.req, "phase value", int'(phase_o), int'(e.ph));
                check(cyc == e.at, e.req, "phase change cycle", int'(cyc), int'(e.at));
                check(load_o == (e.ph == 2'b10), e.req, "load level", int'(load_o),
                      int'(e.ph == 2'b10));
            end
        end
        prev_ph = phase_o;
    end

    // Driver: reset, program, push expected items, wait for completion
    task automatic run_case(input logic [2:0] k1, input logic [3:0] n1,
                            input logic [2:0] k2, input logic [3:0] n2,
                            input string req);
        int unsigned e1;
        int unsigned e2;
        int waited;
        @(posedge clk); #1;
        rst_n = 1'b0;
        start_tap_sel = k1; start_pos_sel = n1;
        run_tap_sel = k2;   run_pos_sel = n2;
        exp_q.delete();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(phase_o == 2'b00 && load_o == 1'b0, "R1", "reset phase/load",
              int'({phase_o, load_o}), 0);
        e1 = span(k1, n1);
        e2 = span(k2, n2);
        exp_q.push_back('{ph: 2'b01, at: e1, req: req});
        exp_q.push_back('{ph: 2'b10, at: e1 + e2, req: req});
        @(posedge clk); #1;
        rst_n = 1'b1;
        waited = 0;
        while (exp_q.size() != 0 && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        check(exp_q.size() == 0, req, "items left after wait", exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        finish_test();
    end

    initial begin
        // R2 R3 R6: fastest setting, one edge per phase
        run_case(3'd0, 4'd1, 3'd0, 4'd1, "R6");
        // R2 R3: mid-range taps and positions
        run_case(3'd2, 4'd5, 3'd1, 4'd3, "R3");
        // R4: position 0 acts as 1
        run_case(3'd1, 4'd0, 3'd3, 4'd0, "R4");
        // R5: positions above 9 act as 9
        run_case(3'd0, 4'd12, 3'd2, 4'd15, "R5");
        // R9: swapped settings swap intervals
        run_case(3'd3, 4'd2, 3'd0, 4'd9, "R9");
        run_case(3'd0, 4'd9, 3'd3, 4'd2, "R9");
        // R2: top tap, top position
        run_case(3'd7, 4'd9, 3'd7, 4'd9, "R2");
        // R7: selects change after completion, outputs hold
        @(posedge clk); #1;
        start_tap_sel = 3'd0; start_pos_sel = 4'd2;
        run_tap_sel = 3'd0;   run_pos_sel = 4'd1;
        repeat (300) @(posedge clk);
        @(negedge clk);
        check(phase_o == 2'b10 && load_o, "R7", "held done state",
              int'({phase_o, load_o}), 5);
        // R10: reset partway through a long delay, then time afresh
        @(posedge clk); #1;
        rst_n = 1'b0;
        start_tap_sel = 3'd5; start_pos_sel = 4'd5;
        repeat (2) @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (50) @(posedge clk);
        @(negedge clk);
        check(phase_o == 2'b00 && !load_o, "R10", "still waiting mid-delay",
              int'({phase_o, load_o}), 0);
        run_case(3'd1, 4'd4, 3'd2, 4'd2, "R10");
        finish_test();
    end

endmodule